// File: doc/BRIEF.md
# Cascadable Bus Request Chain

This block decides bus ownership for one multi-channel DMA controller placed in a series chain of such controllers that share a single external bus arbiter. It merges the local request with the request coming up from lower-priority devices into one bus request line. When the arbiter answers, it decides whether this device takes the bus or lets the grant pass on to the next device in the chain.

The grant and the request from below are sampled on the falling clock edge. The decision is held in a small three-state owner register: idle, owned locally, or owned by a device further down the chain. A grant-enable signal travels down the chain. A device that wants the bus holds it back, but it never takes the grant away from a downstream device that is in the middle of a transfer. A global enable can silence the whole device. A lock output keeps the arbiter from switching owners during the first word of a double-word transfer.

Top module: `dc_bus_chain`

## Requirements
- R1: While reset is low, own_n and lock_n are high and the owner state is idle; the sampled grant and request-in lines reset to their inactive (high) level.
- R2: req_n is low exactly when dma_en is high and either any bit of chan_req is high or the request-in line, as sampled at the last falling edge, is low; otherwise req_n is high.
- R3: grant_n and req_in_n only take effect through their value at a falling clock edge; a low pulse on grant_n that starts and ends between a rising and the following falling edge causes no ownership.
- R4: From idle, when the sampled grant is low, gnt_en_in_n is low, dma_en is high and chan_req is non-zero, own_n goes low at the next rising edge.
- R5: gnt_en_out_n is low exactly when gnt_en_in_n is low, dma_en is high, and either a downstream device owns the bus or the block is idle with no local request.
- R6: A local request that appears while a downstream device owns the bus does not take ownership and does not raise gnt_en_out_n until the sampled grant has gone high; after that the request is served normally.
- R7: A locally owned bus is released (own_n high) at the rising edge after the sampled grant is high or the local request has gone to zero.
- R8: With dma_en low, req_n and gnt_en_out_n are high, no ownership is taken, and a held local ownership ends at the next rising edge.
- R9: lock_n is low exactly when the block owns the bus locally and dbl_first is high.
- R10: With gnt_en_in_n high, no local ownership is taken and gnt_en_out_n stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_en | input | 1 | Global enable, active high |
| chan_req | input | NCH | Per-channel requests from the local channel arbiter, active high |
| dbl_first | input | 1 | High during the first word of a double-word transfer |
| req_in_n | input | 1 | Request from lower-priority device, active low |
| gnt_en_in_n | input | 1 | Grant qualifier from higher-priority device, active low |
| grant_n | input | 1 | Bus grant from the arbiter, active low |
| req_n | output | 1 | Bus request to arbiter or upstream device, active low |
| gnt_en_out_n | output | 1 | Grant qualifier to next device, active low |
| own_n | output | 1 | Local bus ownership acknowledge, active low |
| lock_n | output | 1 | Bus lock for double-word transfers, active low |

## Verification
The chain is driven with a local request alone, a request from below alone, and a local request that arrives while a downstream device holds the grant. These three cases show apart taking the bus, passing it on, and deferring to a transfer already in progress. A grant pulse that does not span a falling edge shows whether sampling uses the correct edge. Runs with the enable low and with the upstream qualifier high show that each of those inputs alone can silence ownership and the outgoing qualifier. Withdrawing either the grant or the request shows that both release paths work.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_LOCAL = 2'd1,
      CH_DOWN  = 2'd2
   } chain_st_t;
endpackage

// File: rtl/dc_sampler.sv
module dc_sampler #(
   parameter int W        = 2,
   parameter int DEPTH    = 1,
   parameter bit NEG_EDGE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [DEPTH];

   if (DEPTH < 1) begin : g_bad_depth
      initial $error("dc_sampler: DEPTH must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      initial $error("dc_sampler: W must be at least 1");
   end

   if (NEG_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '1;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
         end
      end
   end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '1;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[DEPTH-1];
endmodule

// File: rtl/dc_chain_ctl.sv
module dc_chain_ctl
   import dc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  logic      lreq,
   input  logic      rin,
   input  logic      gnt,
   input  logic      gein,
   output logic      bus_req,
   output logic      pass_en,
   output chain_st_t st
);
   chain_st_t st_nx;
   logic      lreq_q;
   logic      rin_q;

   assign lreq_q  = lreq & en;
   assign rin_q   = rin & en;
   assign bus_req = lreq_q | rin_q;
   assign pass_en = gein & en & ((st == CH_DOWN) | ((st == CH_IDLE) & ~lreq_q));

   always_comb begin
      st_nx = st;
      unique case (st)
         CH_IDLE: begin
            if (gnt && gein && lreq_q)     st_nx = CH_LOCAL;
            else if (gnt && gein && en)    st_nx = CH_DOWN;
         end
         CH_LOCAL: begin
            if (!gnt || !lreq_q)           st_nx = CH_IDLE;
         end
         CH_DOWN: begin
            if (!gnt || !en || !gein)      st_nx = CH_IDLE;
         end
         default:                          st_nx = CH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= CH_IDLE;
      else        st <= st_nx;
   end

   p_acquire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_IDLE && gnt && gein && en && lreq) |=> (st == CH_LOCAL));

   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_LOCAL && (!gnt || !lreq)) |=> (st == CH_IDLE));

   p_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_DOWN && gnt && gein && en) |=> (st == CH_DOWN && pass_en));
endmodule

// File: rtl/dc_bus_chain.sv
module dc_bus_chain
   import dc_pkg::*;
#(
   parameter int NCH          = 4,
   parameter int SAMPLE_DEPTH = 1,
   parameter bit SAMPLE_FALL  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           dma_en,
   input  logic [NCH-1:0] chan_req,
   input  logic           dbl_first,
   input  logic           req_in_n,
   input  logic           gnt_en_in_n,
   input  logic           grant_n,
   output logic           req_n,
   output logic           gnt_en_out_n,
   output logic           own_n,
   output logic           lock_n
);
   localparam int SW = 2;

   if (NCH < 1) begin : g_bad_nch
      initial $error("dc_bus_chain: NCH must be at least 1");
   end

   logic [SW-1:0] raw_in;
   logic [SW-1:0] smp;
   logic          any_req;
   logic          bus_req;
   logic          pass_en;
   chain_st_t     st;

   assign raw_in  = {grant_n, req_in_n};
   assign any_req = |chan_req;

   dc_sampler #(
      .W        (SW),
      .DEPTH    (SAMPLE_DEPTH),
      .NEG_EDGE (SAMPLE_FALL)
   ) u_smp (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (smp)
   );

   dc_chain_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (dma_en),
      .lreq    (any_req),
      .rin     (~smp[0]),
      .gnt     (~smp[1]),
      .gein    (~gnt_en_in_n),
      .bus_req (bus_req),
      .pass_en (pass_en),
      .st      (st)
   );

   assign req_n        = ~bus_req;
   assign gnt_en_out_n = ~pass_en;
   assign own_n        = ~(st == CH_LOCAL);
   assign lock_n       = ~((st == CH_LOCAL) & dbl_first);

   p_no_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_n) |-> gnt_en_out_n);

   p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_en) |=> own_n);

   p_gein_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_en_in_n && own_n) |=> own_n);

   p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_n) |-> (!own_n && dbl_first));
endmodule

// File: tb/sim_dc_bus_chain.sv
module sim_dc_bus_chain;
   localparam int PERIOD = 10;
   localparam int NCH    = 4;
   localparam int M_IDLE  = 0;
   localparam int M_LOCAL = 1;
   localparam int M_DOWN  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           dma_en = 1'b1;
   logic [NCH-1:0] chan_req = '0;
   logic           dbl_first = 1'b0;
   logic           req_in_n = 1'b1;
   logic           gnt_en_in_n = 1'b0;
   logic           grant_n = 1'b1;
   logic           req_n, gnt_en_out_n, own_n, lock_n;

   int total = 0;
   int bad = 0;
   int m_st = M_IDLE;

   always #(PERIOD/2) clk = ~clk;

   dc_bus_chain #(.NCH(NCH)) u0 (
      .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .chan_req(chan_req),
      .dbl_first(dbl_first), .req_in_n(req_in_n), .gnt_en_in_n(gnt_en_in_n),
      .grant_n(grant_n), .req_n(req_n), .gnt_en_out_n(gnt_en_out_n),
      .own_n(own_n), .lock_n(lock_n)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
      end
   endtask

   // One clock: drive after the rising edge, compare after the falling edge,
   // then advance the behavioural owner model to the next rising edge.
   task automatic step(input logic [NCH-1:0] lr, input logic rin_n, input logic gein_n,
                       input logic gnt_n, input logic en, input logic dbl,
                       input bit glitch = 1'b0);
      bit lq, rs, gs, ga;
      @(posedge clk);
      #1;
      chan_req = lr; req_in_n = rin_n; gnt_en_in_n = gein_n;
      dma_en = en; dbl_first = dbl;
      if (glitch) begin
         grant_n = 1'b0;
         #2 grant_n = gnt_n;
      end else begin
         grant_n = gnt_n;
      end
      @(negedge clk);
      #3;
      lq = (|lr) && en;
      rs = !rin_n && en;
      gs = !gnt_n;
      ga = !gein_n;
      check("R2 req_n", req_n, !(lq || rs));
      check("R5 gnt_en_out_n", gnt_en_out_n,
            !(ga && en && (m_st == M_DOWN || (m_st == M_IDLE && !lq))));
      check("R4 own_n", own_n, !(m_st == M_LOCAL));
      check("R9 lock_n", lock_n, !(m_st == M_LOCAL && dbl));
      case (m_st)
         M_IDLE:  if (gs && ga && lq) m_st = M_LOCAL;
                  else if (gs && ga && en) m_st = M_DOWN;
         M_LOCAL: if (!gs || !lq) m_st = M_IDLE;
         default: if (!gs || !en || !ga) m_st = M_IDLE;
      endcase
   endtask

   initial begin
      #(PERIOD*5000);
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #3;
      check("R1 own_n in reset", own_n, 1'b1);
      check("R1 lock_n in reset", lock_n, 1'b1);
      check("R1 req_n in reset", req_n, 1'b1);
      @(posedge clk);
      #1 rst_n = 1'b1;

      // idle chain, grant qualifier passes through
      step(4'b0000, 1, 0, 1, 1, 0);
      step(4'b0000, 1, 0, 1, 1, 0);

      // local request takes the bus, lock during first word
      step(4'b0100, 1, 0, 1, 1, 0);
      step(4'b0100, 1, 0, 0, 1, 1);
      step(4'b0100, 1, 0, 0, 1, 1);
      check("R4 local ownership", own_n, 1'b0);
      check("R9 lock on first word", lock_n, 1'b0);
      step(4'b0100, 1, 0, 0, 1, 0);
      step(4'b0000, 1, 0, 0, 1, 0);
      step(4'b0000, 1, 0, 0, 1, 0);
      check("R7 release on request drop", own_n, 1'b1);
      step(4'b0000, 1, 0, 1, 1, 0);
      step(4'b0000, 1, 0, 1, 1, 0);

      // downstream owns, local request must wait
      step(4'b0000, 0, 0, 1, 1, 0);
      check("R2 request from below", req_n, 1'b0);
      step(4'b0000, 0, 0, 0, 1, 0);
      step(4'b0001, 0, 0, 0, 1, 0);
      step(4'b0001, 0, 0, 0, 1, 0);
      step(4'b0001, 0, 0, 0, 1, 0);
      check("R6 waits while downstream owns", own_n, 1'b1);
      check("R6 qualifier held for downstream", gnt_en_out_n, 1'b0);
      step(4'b0001, 1, 0, 1, 1, 0);
      step(4'b0001, 1, 0, 0, 1, 0);
      step(4'b0001, 1, 0, 0, 1, 0);
      check("R6 served after release", own_n, 1'b0);
      step(4'b0001, 1, 0, 1, 1, 0);
      step(4'b0001, 1, 0, 1, 1, 0);
      check("R7 release on grant high", own_n, 1'b1);

      // grant pulse between rising and falling edge is not seen
      step(4'b0010, 1, 0, 1, 1, 0, 1'b1);
      step(4'b0010, 1, 0, 1, 1, 0, 1'b1);
      step(4'b0010, 1, 0, 1, 1, 0, 1'b1);
      check("R3 short grant ignored", own_n, 1'b1);
      step(4'b0000, 1, 0, 1, 1, 0);

      // global enable low
      step(4'b1000, 0, 0, 0, 0, 0);
      step(4'b1000, 0, 0, 0, 0, 0);
      check("R8 req_n silenced", req_n, 1'b1);
      check("R8 qualifier silenced", gnt_en_out_n, 1'b1);
      check("R8 no ownership", own_n, 1'b1);
      step(4'b1000, 1, 0, 1, 1, 0);
      step(4'b1000, 1, 0, 0, 1, 0);
      step(4'b1000, 1, 0, 0, 1, 0);
      check("R4 owned before disable", own_n, 1'b0);
      step(4'b1000, 1, 0, 0, 0, 0);
      step(4'b1000, 1, 0, 0, 0, 0);
      check("R8 ownership ends", own_n, 1'b1);
      step(4'b0000, 1, 0, 1, 1, 0);

      // upstream qualifier inactive
      step(4'b0011, 1, 1, 0, 1, 0);
      step(4'b0011, 1, 1, 0, 1, 0);
      step(4'b0011, 1, 1, 0, 1, 0);
      check("R10 no ownership without qualifier", own_n, 1'b1);
      check("R10 qualifier not passed", gnt_en_out_n, 1'b1);
      step(4'b0000, 1, 0, 1, 1, 0);
      step(4'b0000, 1, 0, 1, 1, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule